// File: doc/BRIEF.md
# Double-Sided Successive Approximation Sequencer

This block sequences a successive approximation converter whose comparator sees two sampled levels: a pixel signal level and a pixel reset level. No trial weight is ever removed. After each comparison the next binary fraction of the reference goes to whichever side currently reads lower, and the two levels close in on each other. The block drives the analog front end. It clears the bit cells, holds the sample window open, strobes the comparator with an active-low pulse, and fires one enable pulse per weight into either the signal-side or the reset-side bit cell.

There are `CELLS` weights, numbered `CELLS-1` down to 0. The heaviest one resolves the sign, and the rest follow from most to least significant. Every decision is shifted into a readout register whose contents mirror the signal-side latches. After the last weight, the comparator inputs are shorted together for `OFS_CELLS` further strobes. Those results form an offset code that later correction logic can use. A single done pulse closes the sequence.

Top module: `dsar_ctrl`

## Requirements
- R1: After sampling, the first strobe resolves the sign (weight `CELLS-1`), and later strobes resolve the weights in descending order. `data_o[CELLS-1]` holds the first decision and `data_o[0]` holds the last.
- R2: One cycle after each data strobe, exactly one enable bit is high for one cycle, at the position of the weight just compared. It is `sig_en_o[k]` if `cmp_i` was 1 (reset reads higher than signal) and `rst_en_o[k]` if it was 0, so the weight always lands on the lower side.
- R3: `cmp_i` is sampled only in cycles where `strobe_n_o` is 0. Its value in any other cycle has no effect on `data_o` or `ofs_o`.
- R4: Each conversion has exactly `CELLS` data strobes with `short_o` low, followed by exactly `OFS_CELLS` strobes with `short_o` high. `short_o` is high only in strobe cycles.
- R5: At the end of a conversion, `data_o` bit k is 1 exactly when the signal-side cell k was enabled during that conversion.
- R6: At the end of a conversion, `ofs_o` holds the offset-phase decisions, with the first one in the MSB.
- R7: A start causes one `clear_o` cycle. `sample_o` is then high for `SAMPLE_CYC` cycles, `data_o` and `ofs_o` read 0 during that window, and `sample_o` is never high while the strobe is low.
- R8: `done_o` is high for exactly one cycle per conversion, in the cycle after the last offset strobe.
- R9: `start_i` is ignored while a conversion is in progress. No second clear or sample window follows.
- R10: After reset, `strobe_n_o` is 1, and every other output, including `data_o` and `ofs_o`, is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a conversion (taken only when idle) |
| cmp_i | input | 1 | Comparator result: 1 when reset level exceeds signal level |
| clear_o | output | 1 | Clear all bit cells on both sides |
| sample_o | output | 1 | Sample/clamp window for both levels |
| strobe_n_o | output | 1 | Comparator strobe, active low |
| short_o | output | 1 | Short comparator inputs for offset measurement |
| sig_en_o | output | CELLS | Per-weight enable for signal-side bit cells |
| rst_en_o | output | CELLS | Per-weight enable for reset-side bit cells |
| data_o | output | CELLS | Decision word (signal-side latch image) |
| ofs_o | output | OFS_CELLS | Offset code |
| done_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
A wrong phase or weight index would show at the ports in the next cycle. The enable would appear on the wrong weight, on the wrong side, or without a strobe in the cycle before it. The bench tracks both analog levels in a model that reacts to each enable, so a misrouted weight also changes later comparator inputs and corrupts the final word within the same conversion. Garbage on the comparator input outside strobes, and a repeated start mid-conversion, show up either in `data_o` at done or as an extra sample window.

// File: rtl/dsar_pkg.sv
package dsar_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CLEAR,
        PH_SAMPLE,
        PH_CMP,
        PH_SET,
        PH_OCMP,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic clear;
        logic sample;
        logic strobe;
        logic shorted;
        logic set;
        logic dshift;
        logic oshift;
        logic done;
    } ctl_t;

    function automatic ctl_t phase_ctl(phase_e p);
        ctl_t c;
        c = '0;
        c.clear   = (p == PH_CLEAR);
        c.sample  = (p == PH_SAMPLE);
        c.strobe  = (p == PH_CMP) || (p == PH_OCMP);
        c.shorted = (p == PH_OCMP);
        c.set     = (p == PH_SET);
        c.dshift  = (p == PH_CMP);
        c.oshift  = (p == PH_OCMP);
        c.done    = (p == PH_DONE);
        return c;
    endfunction

    function automatic int unsigned cnt_width(int unsigned a, int unsigned b);
        return $clog2(((a > b) ? a : b) + 1);
    endfunction

endpackage

// File: rtl/sar_seq.sv
module sar_seq
    import dsar_pkg::*;
#(
    parameter int unsigned CELLS      = 10,
    parameter int unsigned OFS_CELLS  = 5,
    parameter int unsigned SAMPLE_CYC = 2,
    localparam int unsigned IW = $clog2(CELLS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    output phase_e        phase_o,
    output logic [IW-1:0] idx_o
);
    localparam int unsigned CW = cnt_width(SAMPLE_CYC, OFS_CELLS);

    phase_e        phase_q;
    logic [IW-1:0] idx_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (start_i) phase_q <= PH_CLEAR;
                PH_CLEAR: begin
                    phase_q <= PH_SAMPLE;
                    cnt_q   <= '0;
                end
                PH_SAMPLE: begin
                    if (cnt_q == CW'(SAMPLE_CYC - 1)) begin
                        phase_q <= PH_CMP;
                        idx_q   <= IW'(CELLS - 1);
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_CMP: phase_q <= PH_SET;
                PH_SET: begin
                    if (idx_q == '0) begin
                        phase_q <= PH_OCMP;
                        cnt_q   <= '0;
                    end else begin
                        idx_q   <= idx_q - 1'b1;
                        phase_q <= PH_CMP;
                    end
                end
                PH_OCMP: begin
                    if (cnt_q == CW'(OFS_CELLS - 1)) phase_q <= PH_DONE;
                    else cnt_q <= cnt_q + 1'b1;
                end
                PH_DONE: phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o = phase_q;
    assign idx_o   = idx_q;

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        idx_q < IW'(CELLS)); // R1
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && phase_q != PH_DONE && start_i) |=> phase_q != PH_CLEAR); // R9
    AST_SIGN_FIRST: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CMP && $past(phase_q) == PH_SAMPLE) |-> idx_q == IW'(CELLS - 1)); // R1

endmodule

// File: rtl/sar_shreg.sv
module sar_shreg #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         shift_i,
    input  logic         din_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) q <= '0;
        else if (shift_i) q <= {q[W-2:0], din_i};
    end

    assign q_o = q;
endmodule

// File: rtl/sar_endec.sv
module sar_endec #(
    parameter int unsigned CELLS = 10,
    localparam int unsigned IW = $clog2(CELLS)
) (
    input  logic             set_i,
    input  logic             side_i,
    input  logic [IW-1:0]    idx_i,
    output logic [CELLS-1:0] sig_en_o,
    output logic [CELLS-1:0] rst_en_o
);
    for (genvar g = 0; g < CELLS; g++) begin : g_cell
        logic hit;
        assign hit         = set_i && (idx_i == IW'(g));
        assign sig_en_o[g] = hit && side_i;
        assign rst_en_o[g] = hit && !side_i;
    end
endmodule

// File: rtl/dsar_ctrl.sv
module dsar_ctrl
    import dsar_pkg::*;
#(
    parameter int unsigned CELLS      = 10,
    parameter int unsigned OFS_CELLS  = 5,
    parameter int unsigned SAMPLE_CYC = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 cmp_i,
    output logic                 clear_o,
    output logic                 sample_o,
    output logic                 strobe_n_o,
    output logic                 short_o,
    output logic [CELLS-1:0]     sig_en_o,
    output logic [CELLS-1:0]     rst_en_o,
    output logic [CELLS-1:0]     data_o,
    output logic [OFS_CELLS-1:0] ofs_o,
    output logic                 done_o
);
    localparam int unsigned IW = $clog2(CELLS);

    phase_e        phase;
    logic [IW-1:0] idx;
    ctl_t          ctl;

    sar_seq #(.CELLS(CELLS), .OFS_CELLS(OFS_CELLS), .SAMPLE_CYC(SAMPLE_CYC)) i_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .phase_o(phase), .idx_o(idx)
    );

    assign ctl = phase_ctl(phase);

    // Decision word: newest decision sits in bit 0 and drives the side choice.
    sar_shreg #(.W(CELLS)) i_data (
        .clk(clk), .rst(rst), .clr_i(ctl.clear), .shift_i(ctl.dshift),
        .din_i(cmp_i), .q_o(data_o)
    );

    sar_shreg #(.W(OFS_CELLS)) i_ofs (
        .clk(clk), .rst(rst), .clr_i(ctl.clear), .shift_i(ctl.oshift),
        .din_i(cmp_i), .q_o(ofs_o)
    );

    sar_endec #(.CELLS(CELLS)) i_dec (
        .set_i(ctl.set), .side_i(data_o[0]), .idx_i(idx),
        .sig_en_o(sig_en_o), .rst_en_o(rst_en_o)
    );

    assign clear_o    = ctl.clear;
    assign sample_o   = ctl.sample;
    assign strobe_n_o = !ctl.strobe;
    assign short_o    = ctl.shorted;
    assign done_o     = ctl.done;

    AST_EN_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sig_en_o, rst_en_o})); // R2
    AST_EN_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        (|{sig_en_o, rst_en_o}) |-> $past(!strobe_n_o && !short_o)); // R2
    AST_SIDE_MATCH: assert property (@(posedge clk) disable iff (rst)
        (|{sig_en_o, rst_en_o}) |-> ((|sig_en_o) == $past(cmp_i))); // R2
    AST_SAMPLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(sample_o && !strobe_n_o)); // R7
    AST_SHORT_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
        short_o |-> !strobe_n_o); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8
    AST_DONE_AFTER_OFS: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(short_o)); // R8

endmodule

// File: tb/test_dsar_ctrl.sv
module test_dsar_ctrl;
    localparam int CELLS = 10;
    localparam int OFS_CELLS = 5;
    localparam int SAMPLE_CYC = 2;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 0, rst = 1, start_i = 0, cmp_i = 0;
    logic clear_o, sample_o, strobe_n_o, short_o, done_o;
    logic [CELLS-1:0] sig_en_o, rst_en_o, data_o;
    logic [OFS_CELLS-1:0] ofs_o;

    int total = 0, bad = 0;

    dsar_ctrl #(.CELLS(CELLS), .OFS_CELLS(OFS_CELLS), .SAMPLE_CYC(SAMPLE_CYC)) i_dsar_ctrl (
        .clk(clk), .rst(rst), .start_i(start_i), .cmp_i(cmp_i),
        .clear_o(clear_o), .sample_o(sample_o), .strobe_n_o(strobe_n_o),
        .short_o(short_o), .sig_en_o(sig_en_o), .rst_en_o(rst_en_o),
        .data_o(data_o), .ofs_o(ofs_o), .done_o(done_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected word: weight goes to the lower side, decision 1 = reset higher.
    function automatic int exp_word(input int vs, input int vr);
        int w = 0;
        for (int k = CELLS - 1; k >= 0; k--) begin
            if (vr > vs) begin
                w |= (1 << k);
                vs += (1 << k);
            end else begin
                vr += (1 << k);
            end
        end
        return w;
    endfunction

    task automatic run_conv(input int vs0, input int vr0, input int pat, input bit glitch);
        int vs = vs0, vr = vr0;
        int nds = 0, nos = 0, nsamp = 0, nclr = 0, ndone = 0, sigmask = 0;
        bit last = 0, samp_dirty = 0, samp_strobe = 0, short_bad = 0, en_bad = 0;
        bit extra_samp = 0, finished = 0, done_seen = 0;
        int tail = 0;
        @(negedge clk);
        start_i = 1;
        for (int cyc = 0; cyc < 200 && !finished; cyc++) begin
            @(negedge clk);
            start_i = (glitch && (cyc == 6 || cyc == 15)) ? 1'b1 : 1'b0;
            if (done_seen) begin
                tail++;
                if (sample_o || clear_o) extra_samp = 1;
                if (done_o) ndone++;
                if (tail == 4) finished = 1;
                cmp_i = 1'($urandom);
                continue;
            end
            if (clear_o) nclr++;
            if (sample_o) begin
                nsamp++;
                if (data_o != 0 || ofs_o != 0) samp_dirty = 1;
            end
            if (short_o && strobe_n_o) short_bad = 1;
            if ((sig_en_o | rst_en_o) != 0) begin
                int k = CELLS - nds;
                logic [CELLS-1:0] es, er;
                es = last ? CELLS'(1 << k) : '0;
                er = last ? '0 : CELLS'(1 << k);
                chk(sig_en_o == es && rst_en_o == er, "R2", "enable pair",
                    int'({sig_en_o, rst_en_o}), int'({es, er}));
                if (last) begin
                    vs += (1 << k);
                    sigmask |= (1 << k);
                end else vr += (1 << k);
            end
            if (!strobe_n_o) begin
                if (sample_o) samp_strobe = 1;
                if (short_o) begin
                    cmp_i = pat[OFS_CELLS - 1 - nos];
                    nos++;
                end else begin
                    if (nos != 0) en_bad = 1;
                    cmp_i = (vr > vs);
                    last = cmp_i;
                    nds++;
                end
            end else begin
                cmp_i = 1'($urandom); // R3: noise outside strobes
            end
            if (done_o) begin
                ndone++;
                done_seen = 1;
                chk(data_o == CELLS'(exp_word(vs0, vr0)), "R1/R3", "data word",
                    int'(data_o), exp_word(vs0, vr0));
                chk(int'(data_o) == sigmask, "R5", "word vs signal cells",
                    int'(data_o), sigmask);
                chk(int'(ofs_o) == pat, "R6", "offset code", int'(ofs_o), pat);
                chk(nos == OFS_CELLS, "R8", "done after offsets", nos, OFS_CELLS);
            end
        end
        chk(nds == CELLS && !en_bad, "R4", "data strobes", nds, CELLS);
        chk(nos == OFS_CELLS && !short_bad, "R4", "offset strobes", nos, OFS_CELLS);
        chk(nclr == 1 && nsamp == SAMPLE_CYC && !samp_dirty && !samp_strobe, "R7",
            "sample window", nsamp, SAMPLE_CYC);
        chk(ndone == 1, "R8", "done pulses", ndone, 1);
        if (glitch) chk(!extra_samp, "R9", "restart while busy", int'(extra_samp), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired: actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = int'($urandom(32'h5eed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(strobe_n_o && !sample_o && !clear_o && !short_o && !done_o &&
            sig_en_o == 0 && rst_en_o == 0 && data_o == 0 && ofs_o == 0,
            "R10", "reset outputs", int'(data_o), 0);
        // Directed corners
        run_conv(100, 100, 5'b10110, 0);
        run_conv(0, 1023, 5'b11111, 0);
        run_conv(1023, 0, 5'b00000, 0);
        run_conv(300, 301, 5'b00001, 1);
        run_conv(512, 511, 5'b10000, 0);
        // Random
        for (int n = 0; n < 20; n++)
            run_conv(int'($urandom_range(0, 1023)), int'($urandom_range(0, 1023)),
                     int'($urandom_range(0, 31)), 1'($urandom));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule